// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block takes one access from each of 32 lanes and serves them against an on-chip scratchpad made of 32 single-port banks, each one word (32 bits) wide. Every lane presents a word address, an active flag, a write flag and write data. The bank is the low five bits of the word address, and the upper bits select the row inside that bank. In each service cycle the block serves, in every bank, the word chosen by the lowest-numbered lane still waiting on that bank. All waiting lanes that address that same word complete together, so reads of a shared word are broadcast. Lanes that address other words in the same bank wait for later cycles.

A request is taken on `start` while the block is idle. When every active lane has been served, `done` pulses for one cycle. At that point `rdata` holds the read results and `replays` holds the number of service cycles used. The caller issues the next request once it sees `done`.

Top module: `scratch_bank_arb`

## Requirements
- R1: After reset, `busy`, `done`, `replays` and `rdata` are all zero.
- R2: Word address `a` lives in bank `a % 32`, row `a / 32`. When lane i accesses word `base*32 + i`, the request completes in 1 service cycle.
- R3: `replays` equals the largest number of distinct words that active lanes address within any single bank. The minimum is 1, which also covers a request with no active lanes. Thirty-two lanes at a stride of 32 words therefore take 32 cycles.
- R4: Active reading lanes that all address one word each receive that word, and the request takes 1 cycle.
- R5: Every read returns the word's content from before the request. This holds even when other lanes of the same request write that word.
- R6: When several active lanes of one request write the same word, the data of the highest-numbered writing lane is stored.
- R7: `start` and all lane inputs are ignored while `busy` is high. They change neither the stored words nor the result of the request in progress.
- R8: An inactive lane writes nothing. In `rdata`, the slot of an inactive lane and the slot of a writing lane both read as zero. `rdata` changes only while a request is in progress or is being accepted.
- R9: `busy` rises on the clock edge that accepts `start` and stays high for exactly `replays` further edges. `done` is high for the single cycle that follows the last service edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a new request while idle |
| lane_act | input | 32 | Per-lane active flag |
| lane_we | input | 32 | Per-lane write flag |
| lane_addr | input | 320 | Per-lane 10-bit word address; lane i occupies bits [10i+9:10i] |
| lane_wdata | input | 1024 | Per-lane write data; lane i occupies bits [32i+31:32i] |
| busy | output | 1 | A request is being served |
| done | output | 1 | One-cycle pulse when results are valid |
| replays | output | 6 | Service cycles used by the last request |
| rdata | output | 1024 | Per-lane read data, same slot layout as lane_wdata |

## Verification
Within a single service cycle, the broadcast of a word to its readers and the merged write of that word by other lanes can occur together. Reads must return the old content, and only the highest writer's data may be kept. The bench provokes this with directed requests that mix readers and several writers on one word. It also uses random requests drawn from a small address pool, which collide often. Each request is judged against a bench model in which reads see the pre-request memory and the last writer in lane order wins. The cycle count is judged against the largest per-bank count of distinct words.

// File: rtl/scratch_bank_arb.sv
module scratch_bank_arb #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 10,
  parameter int DW    = 32,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LANES-1:0]      lane_act,
  input  logic [LANES-1:0]      lane_we,
  input  logic [LANES*AW-1:0]   lane_addr,
  input  logic [LANES*DW-1:0]   lane_wdata,
  output logic                  busy,
  output logic                  done,
  output logic [CW-1:0]         replays,
  output logic [LANES*DW-1:0]   rdata
);
  localparam int BW   = $clog2(BANKS);
  localparam int RW   = AW - BW;
  localparam int ROWS = 1 << RW;

  logic [LANES-1:0] pend, wr_q, leader, served, remaining;
  logic [AW-1:0]    addr_q [LANES];
  logic [DW-1:0]    wd_q   [LANES];
  logic [DW-1:0]    mem    [BANKS][ROWS];
  logic [CW-1:0]    cnt;

  wire accept = start && !busy;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      leader[l] = pend[l];
      for (int k = 0; k < l; k++)
        if (pend[k] && addr_q[k][BW-1:0] == addr_q[l][BW-1:0]) leader[l] = 1'b0;
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      served[l] = 1'b0;
      for (int k = 0; k < LANES; k++)
        if (leader[k] && addr_q[k] == addr_q[l]) served[l] = pend[l];
    end
  end

  assign remaining = pend & ~served;

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int l = 0; l < LANES; l++) begin
        addr_q[l] <= lane_addr[l*AW +: AW];
        wd_q[l]   <= lane_wdata[l*DW +: DW];
      end
      wr_q <= lane_we;
    end
  end

  always_ff @(posedge clk) begin
    if (busy)
      for (int l = 0; l < LANES; l++)
        if (served[l] && wr_q[l]) mem[addr_q[l][BW-1:0]][addr_q[l][AW-1:BW]] <= wd_q[l];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      replays <= '0;
      rdata   <= '0;
      pend    <= '0;
      cnt     <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        pend  <= lane_act;
        cnt   <= '0;
        rdata <= '0;
      end else if (busy) begin
        cnt  <= cnt + 1'b1;
        pend <= remaining;
        for (int l = 0; l < LANES; l++)
          if (served[l] && !wr_q[l])
            rdata[l*DW +: DW] <= mem[addr_q[l][BW-1:0]][addr_q[l][AW-1:BW]];
        if (remaining == '0) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          replays <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scratch_bank_arb_chk.sv
module scratch_bank_arb_chk #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int CW    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic [CW-1:0]       replays,
  input logic [LANES*DW-1:0] rdata
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_on_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_replay_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (replays >= 1 && replays <= LANES));

  assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_rdata_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(rdata));

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind scratch_bank_arb scratch_bank_arb_chk #(.LANES(LANES), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .replays(replays), .rdata(rdata)
);

// File: tb/scratch_bank_arb_test.sv
module scratch_bank_arb_test;
  localparam int LANES = 32, AW = 10, DW = 32, WORDS = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, junk = 1'b0;
  logic [LANES-1:0] act = '0, we = '0;
  logic [AW-1:0] a  [LANES];
  logic [DW-1:0] wd [LANES];
  logic [LANES*AW-1:0] p_addr;
  logic [LANES*DW-1:0] p_wd;
  logic busy, done;
  logic [5:0] replays;
  logic [LANES*DW-1:0] rdata;
  logic [DW-1:0] model [WORDS];
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  always_comb
    for (int l = 0; l < LANES; l++) begin
      p_addr[l*AW +: AW] = junk ? '0 : a[l];
      p_wd[l*DW +: DW]   = junk ? 32'hDEAD_BEEF : wd[l];
    end

  scratch_bank_arb uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .lane_act(junk ? '1 : act), .lane_we(junk ? '1 : we),
    .lane_addr(p_addr), .lane_wdata(p_wd),
    .busy(busy), .done(done), .replays(replays), .rdata(rdata)
  );

  task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic run(string req, bit inj = 1'b0);
    int exp_cyc = 0, k = 0;
    logic [DW-1:0] exp_rd [LANES];
    for (int b = 0; b < 32; b++) begin
      int n = 0;
      for (int l = 0; l < LANES; l++) begin
        bit fresh = act[l] && a[l][4:0] == b[4:0];
        for (int j = 0; j < l; j++)
          if (act[j] && a[j] == a[l]) fresh = 1'b0;
        if (fresh) n++;
      end
      if (n > exp_cyc) exp_cyc = n;
    end
    if (exp_cyc == 0) exp_cyc = 1;
    for (int l = 0; l < LANES; l++) exp_rd[l] = (act[l] && !we[l]) ? model[a[l]] : '0;
    for (int l = 0; l < LANES; l++) if (act[l] && we[l]) model[a[l]] = wd[l];

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
      if (inj && k == 2) begin junk = 1'b1; start = 1'b1; end
      else if (junk) begin junk = 1'b0; start = 1'b0; end
    end
    check("R9", {req, " edges to done"}, k, exp_cyc);
    check(req, "replays", replays, exp_cyc);
    for (int l = 0; l < LANES; l++) check(req, $sformatf("rdata lane %0d", l), rdata[l*DW +: DW], exp_rd[l]);
    @(negedge clk);
    check("R9", "done single pulse", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int l = 0; l < LANES; l++) begin a[l] = '0; wd[l] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "replays", replays, 0);
    check("R1", "rdata", rdata == '0, 1);

    // R2: fill all words with unit-stride writes
    for (int base = 0; base < 32; base++) begin
      act = '1; we = '1;
      for (int l = 0; l < LANES; l++) begin a[l] = AW'(base*32 + l); wd[l] = $urandom; end
      run("R2");
    end
    act = '1; we = '0;
    for (int l = 0; l < LANES; l++) a[l] = AW'(5*32 + l);
    run("R2");

    // R3: stride 32, one bank
    for (int l = 0; l < LANES; l++) a[l] = AW'(l*32 + 7);
    run("R3");

    // R4: broadcast of one word
    for (int l = 0; l < LANES; l++) a[l] = AW'(77);
    run("R4");

    // R6: many writers to one word, then read back
    we = '1;
    for (int l = 0; l < LANES; l++) begin a[l] = AW'(300); wd[l] = 32'h1000 + l; end
    run("R6");
    we = '0; run("R6");

    // R5: readers and writers share a word in one request
    we = 32'hAAAA_AAAA;
    for (int l = 0; l < LANES; l++) begin a[l] = AW'(450); wd[l] = $urandom; end
    run("R5");
    we = '0; run("R5");

    // R8: inactive lanes with write flags set
    act = 32'h0000_FFFF; we = 32'hFFFF_0000;
    for (int l = 0; l < LANES; l++) begin a[l] = AW'(600 + l); wd[l] = 32'hBAD0_0000 + l; end
    run("R8");
    act = '1; we = '0; run("R8");
    act = '0; run("R3");

    // R7: start and junk inputs during a long request
    act = '1; we = '0;
    for (int l = 0; l < LANES; l++) a[l] = AW'(l*32);
    run("R7", 1'b1);
    for (int l = 0; l < LANES; l++) a[l] = '0;
    run("R7");

    // R3 random: small address pool forces conflicts
    for (int t = 0; t < 80; t++) begin
      act = $urandom; we = $urandom;
      for (int l = 0; l < LANES; l++) begin
        a[l]  = AW'(($urandom % 8) * 32 + ($urandom % 4) + 32 * ($urandom % 3) * (t % 2));
        wd[l] = $urandom;
      end
      run("R3");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule